// File: doc/BRIEF.md
# Backlight Command Slave for an LCD Timing Controller

This block is a write-only slave on a synchronous serial bus. It sits beside an LCD timing controller and takes 8-bit command words. Each word carries a 3-bit register address in its upper bits and a 5-bit data value in its lower bits. From these commands it keeps two pieces of state: a display resolution mode (VGA or quarter-VGA) and the lower five bits of a 6-bit backlight intensity.

The top intensity bit does not come over the bus. It follows an active-low discrete control pin. A separate backlight power pin gates the result. The block drives a 6-bit effective brightness, which reads zero whenever the backlight counts as off, and a one-cycle update strobe that fires whenever that value changes.

The serial clock, chip select and data lines are oversampled in the system clock domain. They pass through synchronizer flops, and rising serial-clock edges are detected there. The receiver is a two-state machine. In `RX_IDLE` it waits, and it moves to `RX_SHIFT` when chip select is seen low. In `RX_SHIFT` it shifts in one bit on each rising serial-clock edge, and it commits a word and restarts its bit count on every eighth bit. It returns to `RX_IDLE`, discarding any partial word, when chip select is seen high.

Top module: `lcd_bl_slave`

## Requirements
- R1: A command word is 8 bits sent MSB first, with one bit sampled on each rising `sck` edge while `cs_n` is low. Bits 7:5 are the register address and bits 4:0 the data.
- R2: A word to address 0 sets `qvga_mode` to 1 when its data is nonzero and to 0 when its data is zero.
- R3: A word to address 2 replaces intensity bits 4:0 with its data and leaves intensity bit 5 alone.
- R4: Intensity bit 5 is the inverse of `bl_hi_n`: a high level clears it and a low level sets it.
- R5: After reset the intensity is 0x20 and `qvga_mode` is 0 (VGA).
- R6: `level` equals the intensity when `bl_power` is high and the intensity is nonzero. Otherwise `level` is 0.
- R7: Words to addresses 1, 3, 4, 5, 6 and 7 are accepted but change neither `qvga_mode` nor the intensity.
- R8: `miso` is always 0.
- R9: A word cut short by `cs_n` rising is discarded, and the next word after `cs_n` falls again starts at bit 7.
- R10: `upd` is high for exactly one cycle in each cycle where `level` takes a new value, and it is low otherwise.
- R11: Several words sent back to back within one `cs_n` low period are each committed on their eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, held at 0 |
| bl_hi_n | input | 1 | Active-low control for intensity bit 5 |
| bl_power | input | 1 | Backlight power enable |
| level | output | 6 | Effective brightness |
| qvga_mode | output | 1 | 1 = quarter-VGA, 0 = VGA |
| upd | output | 1 | One-cycle pulse when `level` changes |

## Verification
The assertions assume the serial inputs change slowly compared with the system clock. Each `sck` level and each `mosi` value must stay stable for several clocks, so that every serial edge is seen exactly once after synchronization. The stimulus keeps each `sck` phase four system clocks long. It changes `mosi` only while `sck` is low, and it moves `cs_n`, `bl_hi_n` and `bl_power` only while `sck` is low and the receiver is between bits. Because of this, the registered intensity, mode and brightness can be compared against the bench model on every clock once each stimulus has settled.

// File: rtl/lcdbl_pkg.sv
package lcdbl_pkg;
    typedef enum logic [0:0] {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    localparam int unsigned REG_RESOLUTION = 0;
    localparam int unsigned REG_DUTY       = 2;
endpackage

// File: rtl/lcdbl_sync.sv
module lcdbl_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lcdbl_rx.sv
module lcdbl_rx
    import lcdbl_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    output logic              commit,
    output logic [WORD_W-1:0] word
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_e        state, state_nx;
    logic             sck_d;
    logic             sck_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic [WORD_W-1:0] shreg;

    assign sck_rise = sck_s && !sck_d;

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (!cs_n_s) state_nx = RX_SHIFT;
            RX_SHIFT: if (cs_n_s)  state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sck_d <= 1'b0;
        end else begin
            state <= state_nx;
            sck_d <= sck_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            word    <= '0;
            commit  <= 1'b0;
        end else begin
            commit <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    bit_cnt <= '0;
                end
                RX_SHIFT: begin
                    if (cs_n_s) begin
                        bit_cnt <= '0;
                    end else if (sck_rise) begin
                        shreg <= {shreg[WORD_W-2:0], mosi_s};
                        if (bit_cnt == LAST_BIT) begin
                            word    <= {shreg[WORD_W-2:0], mosi_s};
                            commit  <= 1'b1;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: bit_cnt <= '0;
            endcase
        end
    end

    // R9: no word is committed in the cycle after chip select is seen high
    assert_no_commit_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !commit);
    // R1: a commit only follows a rising serial clock edge
    assert_commit_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(sck_rise));
endmodule

// File: rtl/lcdbl_regs.sv
module lcdbl_regs
    import lcdbl_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 5,
    parameter int unsigned WORD_W = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    input  logic              hi_n_s,
    output logic [DATA_W:0]   intensity,
    output logic              qvga
);
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] duty_lo;
    logic              top_bit;

    assign addr = word[WORD_W-1:DATA_W];
    assign data = word[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_lo <= '0;
            qvga    <= 1'b0;
            top_bit <= 1'b1;
        end else begin
            top_bit <= !hi_n_s;
            if (commit) begin
                if (addr == ADDR_W'(REG_RESOLUTION)) qvga    <= (data != '0);
                if (addr == ADDR_W'(REG_DUTY))       duty_lo <= data;
            end
        end
    end

    assign intensity = {top_bit, duty_lo};

    // R7: other addresses leave mode and duty bits untouched
    assert_ignored_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr != ADDR_W'(REG_RESOLUTION) && addr != ADDR_W'(REG_DUTY))
        |=> ($stable(duty_lo) && $stable(qvga)));
    // R3: a duty write lands in the low bits
    assert_duty_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == ADDR_W'(REG_DUTY)) |=> (duty_lo == $past(data)));
    // R2: a resolution write selects the mode from its data
    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == ADDR_W'(REG_RESOLUTION)) |=> (qvga == ($past(data) != '0)));
endmodule

// File: rtl/lcdbl_bright.sv
module lcdbl_bright #(
    parameter int unsigned LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] intensity,
    input  logic             pwr_s,
    output logic [LVL_W-1:0] level,
    output logic             upd
);
    logic [LVL_W-1:0] eff;

    always_comb begin
        eff = '0;
        if (pwr_s && intensity != '0) eff = intensity;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
            upd   <= 1'b0;
        end else begin
            level <= eff;
            upd   <= (eff != level);
        end
    end

    // R6: power low forces the output to zero on the next cycle
    assert_off_when_unpowered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> (level == '0));
    // R10: the strobe marks exactly the cycles where the level moved
    assert_strobe_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (level != $past(level)));
    assert_change_has_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> upd);
endmodule

// File: rtl/lcd_bl_slave.sv
module lcd_bl_slave #(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              bl_hi_n,
    input  logic              bl_power,
    output logic [DATA_W:0]   level,
    output logic              qvga_mode,
    output logic              upd
);
    localparam int unsigned WORD_W = ADDR_W + DATA_W;
    localparam int unsigned LVL_W  = DATA_W + 1;

    logic              sck_s, cs_n_s, mosi_s, hi_n_s, pwr_s;
    logic              commit;
    logic [WORD_W-1:0] word;
    logic [LVL_W-1:0]  intensity;

    lcdbl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sck  (.clk(clk), .rst_n(rst_n), .d(sck),      .q(sck_s));
    lcdbl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs   (.clk(clk), .rst_n(rst_n), .d(cs_n),     .q(cs_n_s));
    lcdbl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_mosi (.clk(clk), .rst_n(rst_n), .d(mosi),     .q(mosi_s));
    lcdbl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_hi   (.clk(clk), .rst_n(rst_n), .d(bl_hi_n),  .q(hi_n_s));
    lcdbl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_pwr  (.clk(clk), .rst_n(rst_n), .d(bl_power), .q(pwr_s));

    lcdbl_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .commit(commit), .word(word)
    );

    lcdbl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .word(word), .hi_n_s(hi_n_s),
        .intensity(intensity), .qvga(qvga_mode)
    );

    lcdbl_bright #(.LVL_W(LVL_W)) u_bright (
        .clk(clk), .rst_n(rst_n), .intensity(intensity), .pwr_s(pwr_s),
        .level(level), .upd(upd)
    );

    assign miso = 1'b0;

    // R4: intensity bit 5 tracks the inverted control pin one cycle later
    assert_top_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (intensity[DATA_W] == !$past(hi_n_s)));
endmodule

// File: tb/tb_lcd_bl_slave.sv
module tb_lcd_bl_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic bl_hi_n = 1'b0, bl_power = 1'b0;
    logic miso, qvga_mode, upd;
    logic [5:0] level;

    int n_checks = 0, n_fail = 0;
    int upd_seen = 0;
    bit settled = 0;
    bit done = 0;

    // reference model state
    int m_lo = 0, m_top = 1, m_mode = 0, m_pwr = 0;
    int prev_level = 0;

    always #2.5 clk = ~clk;

    lcd_bl_slave dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .bl_hi_n(bl_hi_n), .bl_power(bl_power), .level(level), .qvga_mode(qvga_mode), .upd(upd)
    );

    function automatic int exp_level();
        int v = m_top * 32 + m_lo;
        return (m_pwr != 0 && v != 0) ? v : 0;
    endfunction

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (upd) upd_seen++;
            check("R8 miso", int'(miso), 0);
            if (settled) begin
                check("R6 level", int'(level), exp_level());
                check("R2 mode", int'(qvga_mode), m_mode);
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(logic [7:0] w, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = w[i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
    endtask

    task automatic begin_op();
        settled = 0;
        prev_level = exp_level();
        upd_seen = 0;
    endtask

    task automatic end_op(string req);
        wait_clk(12);
        settled = 1;
        check(req, int'(level), exp_level());
        check("R10 strobe count", upd_seen, (exp_level() != prev_level) ? 1 : 0);
        wait_clk(3);
    endtask

    task automatic model_word(logic [7:0] w);
        int a = int'(w[7:5]);
        int d = int'(w[4:0]);
        if (a == 0) m_mode = (d != 0) ? 1 : 0;
        if (a == 2) m_lo = d;
    endtask

    task automatic write_word(string req, logic [7:0] w);
        begin_op();
        cs_n = 1'b0;
        wait_clk(4);
        send_bits(w, 8);
        wait_clk(4);
        cs_n = 1'b1;
        model_word(w);
        end_op(req);
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(6);
        settled = 1;
        // R5: reset state
        check("R5 reset level", int'(level), 0);
        check("R5 reset mode", int'(qvga_mode), 0);
        // R5/R6: power on reveals reset intensity 0x20
        begin_op(); bl_power = 1'b1; m_pwr = 1; end_op("R5 intensity 0x20");
        check("R5 level", int'(level), 32);
        // R3: duty write keeps bit 5
        write_word("R3 duty write", 8'b010_10101);
        check("R3 level", int'(level), 53);
        // R4: bit5 control active low
        begin_op(); bl_hi_n = 1'b1; m_top = 0; end_op("R4 clear bit5");
        check("R4 level", int'(level), 21);
        begin_op(); bl_hi_n = 1'b0; m_top = 1; end_op("R4 set bit5");
        // R2: resolution mode
        write_word("R2 qvga", 8'b000_00100);
        check("R2 qvga", int'(qvga_mode), 1);
        write_word("R2 vga", 8'b000_00000);
        check("R2 vga", int'(qvga_mode), 0);
        write_word("R2 qvga again", 8'b000_00001);
        // R7: ignored addresses
        for (int a = 1; a < 8; a++) begin
            if (a != 2) write_word("R7 ignored", {3'(a), 5'b01010});
        end
        check("R7 level kept", int'(level), 53);
        check("R7 mode kept", int'(qvga_mode), 1);
        // R6: zero intensity reads off with power on
        begin_op(); bl_hi_n = 1'b1; m_top = 0; end_op("R6 bit5 low");
        write_word("R6 zero intensity", 8'b010_00000);
        check("R6 zero", int'(level), 0);
        write_word("R6 max low bits", 8'b010_11111);
        begin_op(); bl_hi_n = 1'b0; m_top = 1; end_op("R6 max 63");
        check("R6 max", int'(level), 63);
        // R6: power off
        begin_op(); bl_power = 1'b0; m_pwr = 0; end_op("R6 power off");
        write_word("R6 write while off", 8'b010_00011);
        begin_op(); bl_power = 1'b1; m_pwr = 1; end_op("R6 power back");
        check("R6 power back", int'(level), 35);
        // R9: partial word discarded
        begin_op();
        cs_n = 1'b0; wait_clk(4);
        send_bits(8'b010_11000, 5);
        wait_clk(4); cs_n = 1'b1;
        end_op("R9 partial discarded");
        check("R9 level", int'(level), 35);
        write_word("R9 realigned", 8'b010_00110);
        check("R9 realigned", int'(level), 38);
        // R11: two words in one select period
        begin_op();
        cs_n = 1'b0; wait_clk(4);
        send_bits(8'b000_00000, 8);
        send_bits(8'b010_01001, 8);
        wait_clk(4); cs_n = 1'b1;
        model_word(8'b000_00000);
        model_word(8'b010_01001);
        end_op("R11 back to back");
        check("R11 mode", int'(qvga_mode), 0);
        check("R11 level", int'(level), 41);
        // R1: bit order, MSB first
        write_word("R1 order", 8'b010_00001);
        check("R1 level", int'(level), 33);
        done = 1;
    end

    initial begin
        wait (done);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule